// File: doc/BRIEF.md
# Flash Transfer Byte Counter with Interrupt Latch

This block keeps track of how many data-area bytes remain in a flash page transfer that a separate DMA path carries out, and it turns two events into a maskable interrupt: the count running out, and the flash device signalling ready. A host programs the remaining-byte count through a small register port, sets a run bit, and the DMA side pulses `byte_ack` once per byte moved. While the run bit is set, each pulse lowers the count by one. The count never goes below zero. The run bit stays set until the host clears it.

Each event has its own latched bit. Software can read the latched bits, enable them individually, force them for testing, and clear them by writing ones. The interrupt line is high whenever an enabled latched bit is set. A configuration register holds the transfer direction, burst and ECC-during-DMA selections for neighbouring logic. A status register reports the synchronized ready level and two FIFO-occupancy flags that are supplied from outside.

Top module: `nand_xfer_irq_unit`

## Requirements
- R1: After synchronous reset, every register reads 0 (control, configuration, count, latched events, enable) and `irq` and `xfer_run` are 0.
- R2: A write to address 3 loads the count with `reg_wdata`. Reading address 3 returns the current count.
- R3: The count drops by one per `byte_ack` cycle only while control bit 0 (run, address 0) is 1. With run at 0, pulses leave the count unchanged. Run is not cleared by the count reaching zero; it holds until the host writes it to 0.
- R4: At a count of 0, `byte_ack` leaves the count at 0 and latches no event.
- R5: Latched-event bit 1 (count event) becomes 1 on the clock edge at which a byte decrement takes the count from 1 to 0. Loading the value 0 through address 3 latches nothing.
- R6: A rising edge on `dev_ready_in` sets latched-event bit 0 on the third rising clock edge after the change, following a two-stage synchronizer. A falling edge sets nothing. Status bit 0 (address 2) reads the synchronized level.
- R7: Writing to the clear register (address 7) clears exactly the latched bits written as 1 (bit 1 count, bit 0 ready). Bits written as 0 are left alone.
- R8: Writing to the set register (address 6) forces the latched bits written as 1.
- R9: The latched bits read at address 4. The enable register reads and writes at address 5. `irq` equals the OR of (latched AND enable) bit by bit, and it changes on the same edge as those registers.
- R10: When an event and a clear of the same bit fall on the same edge, the bit ends up set.
- R11: The configuration register (address 1) drives `cfg_read_dir` from bit 1 (1 = read from flash), `cfg_burst` from bit 2 and `cfg_ecc_on` from bit 4, and reads back those bits only. Status bits 1 and 2 reflect `data_fifo_has` and `dma_fifo_has`.
- R12: `xfer_run` is 1 exactly when run is set and the count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| byte_ack | input | 1 | One byte moved by the DMA side this cycle |
| dev_ready_in | input | 1 | Asynchronous device ready level |
| data_fifo_has | input | 1 | Internal data FIFO holds bytes |
| dma_fifo_has | input | 1 | DMA FIFO holds bytes |
| xfer_run | output | 1 | Transfer running with bytes left |
| cfg_read_dir | output | 1 | Direction: 1 read from flash, 0 write |
| cfg_burst | output | 1 | Burst requests enabled |
| cfg_ecc_on | output | 1 | ECC handling during DMA enabled |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, byte decrements, latched events and `irq` all take effect on the edge that samples the stimulus, so the bench checks them at the following falling edge. A read costs one edge, because `reg_rdata` is registered from the address presented in the previous cycle; each read task waits that edge before it samples. The ready path is the slow one. The bench counts the edges one by one after raising `dev_ready_in` and expects `irq` low after the second edge and high after the third. A combined byte-and-clear stimulus lands on one edge to check which action takes priority.

// File: rtl/nxi_pkg.sv
package nxi_pkg;

  typedef enum logic [2:0] {
    RA_CTRL    = 3'd0,
    RA_CFG     = 3'd1,
    RA_STAT    = 3'd2,
    RA_COUNT   = 3'd3,
    RA_IRQ_RAW = 3'd4,
    RA_IRQ_EN  = 3'd5,
    RA_IRQ_SET = 3'd6,
    RA_IRQ_CLR = 3'd7
  } nxi_reg_e;

  localparam int NUM_EVT   = 2;
  localparam int EVT_RDY   = 0;
  localparam int EVT_TC    = 1;

  localparam int CTRL_RUN  = 0;

  localparam int CFG_DIR   = 1;
  localparam int CFG_BURST = 2;
  localparam int CFG_ECC   = 4;

  localparam int ST_RDY    = 0;
  localparam int ST_DFIFO  = 1;
  localparam int ST_DMAF   = 2;

endpackage

// File: rtl/nxi_tc_counter.sv
module nxi_tc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             byte_ack,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic dec;

  // A byte is only taken while running with bytes left; a load overrides.
  assign dec      = run && byte_ack && (cnt != '0) && !load;
  assign hit_zero = dec && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - ONE;
  end
endmodule

// File: rtl/nxi_rdy_sync.sv
module nxi_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out,
  output logic rise
);
  logic prev;

  generate
    if (STAGES == 1) begin : g_single
      logic s1;
      always_ff @(posedge clk) begin
        if (rst) s1 <= 1'b0;
        else     s1 <= async_in;
      end
      assign sync_out = s1;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], async_in};
      end
      assign sync_out = sh[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sync_out;
  end

  assign rise = sync_out && !prev;
endmodule

// File: rtl/nxi_irq_bank.sv
module nxi_irq_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  input  logic         en_wr,
  input  logic [N-1:0] en_val,
  output logic [N-1:0] raw,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] raw_nxt;
  logic [N-1:0] en_nxt;

  // Per bit: hardware event or software set beats a clear on the same edge.
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign raw_nxt[i] = evt[i] | set_mask[i] | (raw[i] & ~clr_mask[i]);
    end
  endgenerate

  assign en_nxt = en_wr ? en_val : en;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      raw <= raw_nxt;
      en  <= en_nxt;
      irq <= |(raw_nxt & en_nxt);
    end
  end
endmodule

// File: rtl/nand_xfer_irq_unit.sv
module nand_xfer_irq_unit
  import nxi_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              byte_ack,
  input  logic              dev_ready_in,
  input  logic              data_fifo_has,
  input  logic              dma_fifo_has,
  output logic              xfer_run,
  output logic              cfg_read_dir,
  output logic              cfg_burst,
  output logic              cfg_ecc_on,
  output logic              irq
);
  logic             start_q;
  logic [CNT_W-1:0] count_val;
  logic             tc_hit;
  logic             rdy_level;
  logic             rdy_rise;
  logic [NUM_EVT-1:0] irq_raw;
  logic [NUM_EVT-1:0] irq_en;
  logic [NUM_EVT-1:0] evt_vec;
  logic [NUM_EVT-1:0] set_mask;
  logic [NUM_EVT-1:0] clr_mask;

  logic wr_ctrl, wr_cfg, wr_count, wr_en, wr_set, wr_clr;

  assign wr_ctrl  = reg_wen && (reg_addr == RA_CTRL);
  assign wr_cfg   = reg_wen && (reg_addr == RA_CFG);
  assign wr_count = reg_wen && (reg_addr == RA_COUNT);
  assign wr_en    = reg_wen && (reg_addr == RA_IRQ_EN);
  assign wr_set   = reg_wen && (reg_addr == RA_IRQ_SET);
  assign wr_clr   = reg_wen && (reg_addr == RA_IRQ_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q      <= 1'b0;
      cfg_read_dir <= 1'b0;
      cfg_burst    <= 1'b0;
      cfg_ecc_on   <= 1'b0;
    end else begin
      if (wr_ctrl) start_q <= reg_wdata[CTRL_RUN];
      if (wr_cfg) begin
        cfg_read_dir <= reg_wdata[CFG_DIR];
        cfg_burst    <= reg_wdata[CFG_BURST];
        cfg_ecc_on   <= reg_wdata[CFG_ECC];
      end
    end
  end

  nxi_tc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_count),
    .load_val (reg_wdata[CNT_W-1:0]),
    .run      (start_q),
    .byte_ack (byte_ack),
    .cnt      (count_val),
    .hit_zero (tc_hit)
  );

  nxi_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (dev_ready_in),
    .sync_out (rdy_level),
    .rise     (rdy_rise)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[EVT_TC]  = tc_hit;
    evt_vec[EVT_RDY] = rdy_rise;
  end

  assign set_mask = reg_wdata[NUM_EVT-1:0] & {NUM_EVT{wr_set}};
  assign clr_mask = reg_wdata[NUM_EVT-1:0] & {NUM_EVT{wr_clr}};

  nxi_irq_bank #(.N(NUM_EVT)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_vec),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .en_wr    (wr_en),
    .en_val   (reg_wdata[NUM_EVT-1:0]),
    .raw      (irq_raw),
    .en       (irq_en),
    .irq      (irq)
  );

  assign xfer_run = start_q && (count_val != '0);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (nxi_reg_e'(reg_addr))
      RA_CTRL:    rd_mux[CTRL_RUN] = start_q;
      RA_CFG: begin
        rd_mux[CFG_DIR]   = cfg_read_dir;
        rd_mux[CFG_BURST] = cfg_burst;
        rd_mux[CFG_ECC]   = cfg_ecc_on;
      end
      RA_STAT: begin
        rd_mux[ST_RDY]   = rdy_level;
        rd_mux[ST_DFIFO] = data_fifo_has;
        rd_mux[ST_DMAF]  = dma_fifo_has;
      end
      RA_COUNT:   rd_mux = DATA_W'(count_val);
      RA_IRQ_RAW: rd_mux[NUM_EVT-1:0] = irq_raw;
      RA_IRQ_EN:  rd_mux[NUM_EVT-1:0] = irq_en;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/nxi_checker.sv
module nxi_checker
  import nxi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wen,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               byte_ack,
  input logic               irq,
  input logic               start_q,
  input logic [CNT_W-1:0]   count_val,
  input logic [NUM_EVT-1:0] irq_raw,
  input logic [NUM_EVT-1:0] irq_en
);
  logic cnt_load;
  assign cnt_load = reg_wen && (reg_addr == RA_COUNT);

  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (start_q && byte_ack && count_val != '0 && !cnt_load)
      |=> count_val == $past(count_val) - CNT_W'(1));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!start_q && !cnt_load) |=> $stable(count_val));

  assert_floor_R4: assert property (@(posedge clk) disable iff (rst)
    (count_val == '0 && !cnt_load) |=> count_val == '0);

  assert_tc_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (start_q && byte_ack && count_val == CNT_W'(1) && !cnt_load)
      |=> irq_raw[EVT_TC]);

  assert_clear_only_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_raw[EVT_TC])
      |-> $past(reg_wen && reg_addr == RA_IRQ_CLR && reg_wdata[EVT_TC]));

  assert_force_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == RA_IRQ_SET && reg_wdata[EVT_RDY])
      |=> irq_raw[EVT_RDY]);

  assert_irq_line_R9: assert property (@(posedge clk) disable iff (rst)
    irq == |(irq_raw & irq_en));
endmodule

bind nand_xfer_irq_unit nxi_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wen   (reg_wen),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .byte_ack  (byte_ack),
  .irq       (irq),
  .start_q   (start_q),
  .count_val (count_val),
  .irq_raw   (irq_raw),
  .irq_en    (irq_en)
);

// File: tb/sim_nand_xfer_irq_unit.sv
module sim_nand_xfer_irq_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wen = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        byte_ack = 1'b0;
  logic        dev_ready_in = 1'b0;
  logic        data_fifo_has = 1'b0;
  logic        dma_fifo_has = 1'b0;
  logic        xfer_run, cfg_read_dir, cfg_burst, cfg_ecc_on, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  nand_xfer_irq_unit u0 (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_ack(byte_ack),
    .dev_ready_in(dev_ready_in), .data_fifo_has(data_fifo_has),
    .dma_fifo_has(dma_fifo_has), .xfer_run(xfer_run),
    .cfg_read_dir(cfg_read_dir), .cfg_burst(cfg_burst),
    .cfg_ecc_on(cfg_ecc_on), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wen = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin
      byte_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      byte_ack = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 reg %0d after reset", a), v, 32'd0);
    end
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 xfer_run after reset", {31'd0, xfer_run}, 32'd0);
  endtask

  task automatic t_config;
    logic [31:0] v;
    wr(3'd1, 32'hFFFF_FFFF);
    check("R11 config pins", {29'd0, cfg_read_dir, cfg_burst, cfg_ecc_on}, 32'd7);
    rd(3'd1, v);
    check("R11 config readback masked", v, 32'h16);
    wr(3'd1, 32'h4);
    check("R11 config burst only", {29'd0, cfg_read_dir, cfg_burst, cfg_ecc_on}, 32'd2);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(3'd3, 32'd5);
    rd(3'd3, v);
    check("R2 count load", v, 32'd5);
    bytes(2);
    rd(3'd3, v);
    check("R3 no decrement while stopped", v, 32'd5);
    check("R12 xfer_run while stopped", {31'd0, xfer_run}, 32'd0);
    wr(3'd0, 32'd1);
    check("R12 xfer_run after start", {31'd0, xfer_run}, 32'd1);
    bytes(3);
    rd(3'd3, v);
    check("R3 three decrements", v, 32'd2);
    rd(3'd4, v);
    check("R5 no event before zero", v, 32'd0);
  endtask

  task automatic t_terminal;
    logic [31:0] v;
    bytes(2);
    rd(3'd3, v);
    check("R3 count reaches zero", v, 32'd0);
    rd(3'd4, v);
    check("R5 count event latched", v, 32'd2);
    check("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd5, 32'd2);
    check("R9 irq after enable", {31'd0, irq}, 32'd1);
    check("R12 xfer_run at zero", {31'd0, xfer_run}, 32'd0);
    rd(3'd0, v);
    check("R3 run stays set", v, 32'd1);
  endtask

  task automatic t_saturate;
    logic [31:0] v;
    wr(3'd7, 32'd2);
    check("R7 irq after clear", {31'd0, irq}, 32'd0);
    bytes(3);
    rd(3'd3, v);
    check("R4 count floor", v, 32'd0);
    rd(3'd4, v);
    check("R4 no event at floor", v, 32'd0);
    wr(3'd3, 32'd0);
    rd(3'd4, v);
    check("R5 zero load no event", v, 32'd0);
  endtask

  task automatic t_set_clear;
    logic [31:0] v;
    wr(3'd6, 32'd3);
    rd(3'd4, v);
    check("R8 set both", v, 32'd3);
    wr(3'd7, 32'd0);
    rd(3'd4, v);
    check("R7 zero clear keeps", v, 32'd3);
    wr(3'd7, 32'd1);
    rd(3'd4, v);
    check("R7 clear ready only", v, 32'd2);
    wr(3'd7, 32'd3);
  endtask

  task automatic t_ready;
    logic [31:0] v;
    wr(3'd5, 32'd1);
    dev_ready_in = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R6 irq not yet after two edges", {31'd0, irq}, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R6 irq on third edge", {31'd0, irq}, 32'd1);
    rd(3'd2, v);
    check("R6 status ready level", v, 32'd1);
    wr(3'd7, 32'd1);
    dev_ready_in = 1'b0;
    repeat (5) begin @(posedge clk); @(negedge clk); end
    rd(3'd4, v);
    check("R6 falling edge ignored", v, 32'd0);
  endtask

  task automatic t_race;
    logic [31:0] v;
    wr(3'd5, 32'd2);
    wr(3'd3, 32'd1);
    byte_ack = 1'b1; reg_wen = 1'b1; reg_addr = 3'd7; reg_wdata = 32'd2;
    @(posedge clk); @(negedge clk);
    byte_ack = 1'b0; reg_wen = 1'b0; reg_wdata = 32'd0;
    check("R10 event beats clear irq", {31'd0, irq}, 32'd1);
    rd(3'd4, v);
    check("R10 event beats clear raw", v, 32'd2);
  endtask

  task automatic t_status;
    logic [31:0] v;
    data_fifo_has = 1'b1; dma_fifo_has = 1'b1;
    rd(3'd2, v);
    check("R11 fifo flags", v, 32'd6);
    data_fifo_has = 1'b0;
    rd(3'd2, v);
    check("R11 dma flag only", v, 32'd4);
    dma_fifo_has = 1'b0;
  endtask

  task automatic t_stop;
    logic [31:0] v;
    wr(3'd0, 32'd0);
    wr(3'd3, 32'd4);
    check("R12 xfer_run after stop", {31'd0, xfer_run}, 32'd0);
    bytes(2);
    rd(3'd3, v);
    check("R3 stop freezes count", v, 32'd4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_config();
    t_count();
    t_terminal();
    t_saturate();
    t_set_clear();
    t_ready();
    t_race();
    t_status();
    t_stop();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule